// File: doc/BRIEF.md
# Network media port auto-selector

This block chooses which of three media ports an Ethernet MAC drives: a twisted-pair port, an attachment-unit port, or a general-purpose serial port. Three configuration bits come in through a write interface: an auto-select enable, a 2-bit manual port code, and a polarity bit for an external transceiver control pin. The block combines them with a sampled twisted-pair link status to pick a port. A port change never takes effect while a frame is being transmitted.

Besides a one-hot active-port indication, the block drives the transceiver control pin and an enable for link-beat pulses on the twisted-pair port. That enable is derived from the configuration, not from the chosen port. A hard reset (asynchronous) loads the configuration defaults. A soft reset and a stop command leave the configuration untouched. A reserved manual code raises a sticky error flag that software can read back.

Top module: `msel_port_selector`

## Requirements
- R1: While and after hard reset, the auto-select bit reads 1, the manual code reads 00, the polarity bit reads 0, the error flag reads 0 and the active port is the attachment-unit port (encoding 3'b001).
- R2: The active-port output is one-hot: bit 0 is the attachment-unit port, bit 1 is twisted-pair, bit 2 is the serial port. Manual code 10 selects the serial port whatever the auto-select bit holds.
- R3: With auto-select set and a manual code other than 10, a passing link selects twisted-pair and a failing link selects attachment-unit. Link status passes through LINK_SYNC_STAGES flops, so the port follows a link change LINK_SYNC_STAGES+1 clock edges later.
- R4: With auto-select clear, code 00 selects attachment-unit, 01 selects twisted-pair and 10 selects serial. A write takes effect on the register at its clock edge and on the active port at the next edge.
- R5: At any edge where the transmit-busy input is high, the active port keeps its value. A pending change is applied at the first edge where transmit-busy is low.
- R6: Manual code 11 with auto-select clear keeps the previously active port. While the code register holds 11, the error flag is set at each clock edge, and it stays set until a soft or hard reset.
- R7: A soft reset clears the error flag at the edge where it is sampled.
- R8: The link-beat enable is high when auto-select is set or the manual code is 01, and low otherwise.
- R9: With polarity 0, the transceiver control output is low when twisted-pair is active and high otherwise. Polarity 1 inverts this.
- R10: Soft reset and the stop command leave the auto-select, manual code, polarity and active-port state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous hard reset, active low |
| softRst | input | 1 | Synchronous soft reset; clears only the error flag |
| stopCmd | input | 1 | Stop command; no effect on this block's state |
| wrEn | input | 1 | Writes the three configuration fields |
| wrAutoSel | input | 1 | Auto-select value to write |
| wrPortSel | input | 2 | Manual port code to write |
| wrPolarity | input | 1 | Transceiver control polarity to write |
| linkPass | input | 1 | Twisted-pair link status, 1 = pass |
| txBusy | input | 1 | A frame is being transmitted |
| activePort | output | 3 | One-hot active port |
| linkBeatEn | output | 1 | Enable for link-beat pulses on twisted-pair |
| xcvrCtl | output | 1 | External transceiver control pin |
| cfgErr | output | 1 | Sticky reserved-code error flag |
| rdAutoSel | output | 1 | Auto-select readback |
| rdPortSel | output | 2 | Manual code readback |
| rdPolarity | output | 1 | Polarity readback |

## Verification
Each result has a fixed latency:
- A configuration write shows on the readback and the link-beat enable right after its edge.
- The active port and the transceiver pin follow one edge after a write.
- The active port follows LINK_SYNC_STAGES+1 edges after a link change.
- The error flag sets one edge after the code register holds 11.

A behavioural model in the bench advances at every rising edge using the inputs applied before it. All outputs are compared at the falling edge, so every latency is checked exactly. Inputs change two time units after the rising edge. The directed checks wait whole cycles past the latencies above before sampling.

// File: rtl/msel_pkg.sv
package msel_pkg;
  localparam int NUM_PORTS = 3;
  localparam int PSEL_W    = 2;

  typedef enum logic [NUM_PORTS-1:0] {
    PORT_AUI = 3'b001,
    PORT_TP  = 3'b010,
    PORT_SER = 3'b100
  } port_t;

  localparam logic [PSEL_W-1:0] SEL_AUI = 2'b00;
  localparam logic [PSEL_W-1:0] SEL_TP  = 2'b01;
  localparam logic [PSEL_W-1:0] SEL_SER = 2'b10;
  localparam logic [PSEL_W-1:0] SEL_RSV = 2'b11;

  typedef struct packed {
    logic  loadPort;
    port_t nextPort;
  } msel_strobe_t;
endpackage

// File: rtl/msel_ctrl.sv
module msel_ctrl
  import msel_pkg::*;
(
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              stopCmd,
  input  logic              wrEn,
  input  logic              wrAutoSel,
  input  logic [PSEL_W-1:0] wrPortSel,
  input  logic              wrPolarity,
  input  logic              linkQ,
  input  logic              txBusy,
  input  port_t             activePort,
  output msel_strobe_t      strobe,
  output logic              autoSel,
  output logic [PSEL_W-1:0] portSel,
  output logic              polarity,
  output logic              cfgErr,
  output logic              linkBeatEn
);
  port_t wantPort;

  // configuration bits: only hard reset or a write change them
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      autoSel  <= 1'b1;
      portSel  <= SEL_AUI;
      polarity <= 1'b0;
    end else if (wrEn) begin
      autoSel  <= wrAutoSel;
      portSel  <= wrPortSel;
      polarity <= wrPolarity;
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)    cfgErr <= 1'b0;
    else if (softRst) cfgErr <= 1'b0;
    else if (portSel == SEL_RSV) cfgErr <= 1'b1;
  end

  always_comb begin
    wantPort = activePort;
    if (portSel == SEL_SER) begin
      wantPort = PORT_SER;
    end else if (autoSel) begin
      wantPort = linkQ ? PORT_TP : PORT_AUI;
    end else begin
      case (portSel)
        SEL_AUI: wantPort = PORT_AUI;
        SEL_TP:  wantPort = PORT_TP;
        default: wantPort = activePort;
      endcase
    end
  end

  assign strobe.loadPort = !txBusy && (wantPort != activePort);
  assign strobe.nextPort = wantPort;
  assign linkBeatEn      = autoSel | (portSel == SEL_TP);

  AST_SER_FORCED: assert property (@(posedge clk) disable iff (!hardRstN)
    (portSel == SEL_SER && !txBusy) |=> activePort == PORT_SER); // R2
  AST_AUTO_LINK: assert property (@(posedge clk) disable iff (!hardRstN)
    (autoSel && portSel != SEL_SER && !txBusy) |=>
      activePort == ($past(linkQ) ? PORT_TP : PORT_AUI)); // R3
  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!hardRstN)
    (!autoSel && portSel == SEL_RSV) |=> $stable(activePort)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!hardRstN)
    (cfgErr && !softRst) |=> cfgErr); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!hardRstN)
    softRst |=> !cfgErr); // R7
  AST_STOP_KEEP: assert property (@(posedge clk) disable iff (!hardRstN)
    ((stopCmd || softRst) && !wrEn) |=>
      ($stable(autoSel) && $stable(portSel) && $stable(polarity))); // R10
endmodule

// File: rtl/msel_datapath.sv
module msel_datapath
  import msel_pkg::*;
#(
  parameter int LINK_SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         hardRstN,
  input  logic         linkPass,
  input  logic         txBusy,
  input  msel_strobe_t strobe,
  input  logic         polarity,
  output logic         linkQ,
  output port_t        activePort,
  output logic         xcvrCtl
);
  logic [LINK_SYNC_STAGES-1:0] linkChain;

  generate
    if (LINK_SYNC_STAGES == 1) begin : g_link1
      always_ff @(posedge clk or negedge hardRstN) begin
        if (!hardRstN) linkChain <= '0;
        else           linkChain <= linkPass;
      end
    end else begin : g_linkN
      always_ff @(posedge clk or negedge hardRstN) begin
        if (!hardRstN) linkChain <= '0;
        else           linkChain <= {linkChain[LINK_SYNC_STAGES-2:0], linkPass};
      end
    end
  endgenerate

  assign linkQ = linkChain[LINK_SYNC_STAGES-1];

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)           activePort <= PORT_AUI;
    else if (strobe.loadPort) activePort <= strobe.nextPort;
  end

  assign xcvrCtl = (activePort != PORT_TP) ^ polarity;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!hardRstN)
    txBusy |=> $stable(activePort)); // R5
  AST_PORT_ONEHOT: assert property (@(posedge clk) disable iff (!hardRstN)
    $onehot(activePort)); // R2
endmodule

// File: rtl/msel_port_selector.sv
module msel_port_selector
  import msel_pkg::*;
#(
  parameter int LINK_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       hardRstN,
  input  logic       softRst,
  input  logic       stopCmd,
  input  logic       wrEn,
  input  logic       wrAutoSel,
  input  logic [1:0] wrPortSel,
  input  logic       wrPolarity,
  input  logic       linkPass,
  input  logic       txBusy,
  output logic [2:0] activePort,
  output logic       linkBeatEn,
  output logic       xcvrCtl,
  output logic       cfgErr,
  output logic       rdAutoSel,
  output logic [1:0] rdPortSel,
  output logic       rdPolarity
);
  msel_strobe_t strobe;
  port_t        activeQ;
  logic         linkQ;
  logic         polarity;

  msel_ctrl u_ctrl (
    .clk        (clk),
    .hardRstN   (hardRstN),
    .softRst    (softRst),
    .stopCmd    (stopCmd),
    .wrEn       (wrEn),
    .wrAutoSel  (wrAutoSel),
    .wrPortSel  (wrPortSel),
    .wrPolarity (wrPolarity),
    .linkQ      (linkQ),
    .txBusy     (txBusy),
    .activePort (activeQ),
    .strobe     (strobe),
    .autoSel    (rdAutoSel),
    .portSel    (rdPortSel),
    .polarity   (polarity),
    .cfgErr     (cfgErr),
    .linkBeatEn (linkBeatEn)
  );

  msel_datapath #(.LINK_SYNC_STAGES(LINK_SYNC_STAGES)) u_dp (
    .clk        (clk),
    .hardRstN   (hardRstN),
    .linkPass   (linkPass),
    .txBusy     (txBusy),
    .strobe     (strobe),
    .polarity   (polarity),
    .linkQ      (linkQ),
    .activePort (activeQ),
    .xcvrCtl    (xcvrCtl)
  );

  assign activePort = activeQ;
  assign rdPolarity = polarity;
endmodule

// File: tb/msel_port_selector_tb.sv
module msel_port_selector_tb_top;
  localparam int LS = 2;

  logic clk = 1'b0;
  logic hardRstN = 1'b0;
  logic softRst = 1'b0, stopCmd = 1'b0, wrEn = 1'b0;
  logic wrAutoSel = 1'b0, wrPolarity = 1'b0;
  logic [1:0] wrPortSel = 2'b00;
  logic linkPass = 1'b0, txBusy = 1'b0;
  logic [2:0] activePort;
  logic linkBeatEn, xcvrCtl, cfgErr, rdAutoSel, rdPolarity;
  logic [1:0] rdPortSel;

  int testCnt = 0, failCnt = 0, cycCnt = 0;
  bit started = 0, done = 0;

  // reference model state
  bit mAuto = 1, mPol = 0, mErr = 0;
  int mSel = 0, mActive = 1;
  bit mLink [LS];

  always #5 clk = ~clk;

  msel_port_selector #(.LINK_SYNC_STAGES(LS)) dut_i (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .stopCmd(stopCmd),
    .wrEn(wrEn), .wrAutoSel(wrAutoSel), .wrPortSel(wrPortSel),
    .wrPolarity(wrPolarity), .linkPass(linkPass), .txBusy(txBusy),
    .activePort(activePort), .linkBeatEn(linkBeatEn), .xcvrCtl(xcvrCtl),
    .cfgErr(cfgErr), .rdAutoSel(rdAutoSel), .rdPortSel(rdPortSel),
    .rdPolarity(rdPolarity)
  );

  task automatic chk(input string tag, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      mAuto = 1; mSel = 0; mPol = 0; mErr = 0; mActive = 1;
      for (int i = 0; i < LS; i++) mLink[i] = 0;
    end else begin
      int want;
      want = mActive;
      if (mSel == 2) want = 4;
      else if (mAuto) want = mLink[LS-1] ? 2 : 1;
      else if (mSel == 0) want = 1;
      else if (mSel == 1) want = 2;
      if (!txBusy) mActive = want;
      mErr = softRst ? 0 : (mErr || mSel == 3);
      for (int i = LS-1; i > 0; i--) mLink[i] = mLink[i-1];
      mLink[0] = linkPass;
      if (wrEn) begin
        mAuto = wrAutoSel; mSel = int'(wrPortSel); mPol = wrPolarity;
      end
    end
  end

  always @(posedge clk) begin
    cycCnt++;
    started = 1;
    if (cycCnt > 20000 && !done) begin
      done = 1;
      failCnt++;
      testCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycCnt, 20000);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("active port R2 R3 R4 R5 R6", int'(activePort), mActive);
      chk("link beat R8", int'(linkBeatEn), int'(mAuto || mSel == 1));
      chk("xcvr pin R9", int'(xcvrCtl), int'((mActive != 2) ^ mPol));
      chk("error flag R6 R7", int'(cfgErr), int'(mErr));
      chk("readback R1 R10", int'({rdAutoSel, rdPortSel, rdPolarity}),
          int'({mAuto, mSel[1:0], mPol}));
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic doWrite(input bit a, input bit [1:0] s, input bit p);
    waitCyc(1);
    wrEn = 1; wrAutoSel = a; wrPortSel = s; wrPolarity = p;
    waitCyc(1);
    wrEn = 0;
  endtask

  initial begin
    waitCyc(3);
    chk("R1 reset port", int'(activePort), 1);
    chk("R1 reset cfg", int'({rdAutoSel, rdPortSel, rdPolarity, cfgErr}), 5'b10000);
    hardRstN = 1;
    waitCyc(4);
    chk("R3 link fail gives AUI", int'(activePort), 1);
    linkPass = 1;
    waitCyc(LS + 2);
    chk("R3 link pass gives TP", int'(activePort), 2);
    chk("R9 TP pin low", int'(xcvrCtl), 0);
    txBusy = 1; linkPass = 0;
    waitCyc(6);
    chk("R5 held while busy", int'(activePort), 2);
    txBusy = 0;
    waitCyc(1);
    chk("R5 first idle edge", int'(activePort), 1);
    doWrite(1, 2'b10, 0);
    waitCyc(2);
    chk("R2 serial forced", int'(activePort), 4);
    doWrite(0, 2'b01, 1);
    chk("R8 manual TP beat", int'(linkBeatEn), 1);
    waitCyc(1);
    chk("R4 manual TP", int'(activePort), 2);
    chk("R9 inverted pin", int'(xcvrCtl), 1);
    doWrite(0, 2'b11, 1);
    chk("R8 beat off", int'(linkBeatEn), 0);
    linkPass = 1;
    waitCyc(LS + 2);
    chk("R6 reserved holds", int'(activePort), 2);
    chk("R6 error set", int'(cfgErr), 1);
    doWrite(0, 2'b00, 0);
    waitCyc(2);
    chk("R4 manual AUI", int'(activePort), 1);
    chk("R6 error sticky", int'(cfgErr), 1);
    stopCmd = 1;
    waitCyc(2);
    stopCmd = 0;
    softRst = 1;
    waitCyc(1);
    softRst = 0;
    chk("R7 soft reset clears error", int'(cfgErr), 0);
    chk("R10 config kept", int'({rdAutoSel, rdPortSel, rdPolarity}), 4'b0000);
    chk("R10 port kept", int'(activePort), 1);
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(7) == 0) linkPass = ~linkPass;
      txBusy  = ($urandom_range(2) == 0);
      softRst = ($urandom_range(29) == 0);
      stopCmd = ($urandom_range(9) == 0);
      wrEn    = ($urandom_range(9) == 0);
      wrAutoSel  = 1'($urandom_range(1));
      wrPortSel  = 2'($urandom_range(3));
      wrPolarity = 1'($urandom_range(1));
      waitCyc(1);
    end
    wrEn = 0; softRst = 0; stopCmd = 0; txBusy = 0;
    hardRstN = 0;
    #1;
    chk("R1 async reset port", int'(activePort), 1);
    waitCyc(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule